// File: doc/BRIEF.md
# Split-Lane Data Register File

This block is the data-side register file of a floating-point/integer arithmetic unit. Each of its entries is 96 bits wide and divided into three 32-bit lanes: upper (95:64), centre (63:32) and bottom (31:0). A write names a destination entry and a write kind. The kind, together with a split-mode bit held in a 32-bit control word, decides which lanes the write updates, which lanes it clears and which it leaves alone.

With split mode on, single-precision writes own the upper and centre lanes, and integer multiplies own the bottom lane. One entry can then hold a single-precision value and a 32-bit integer at the same time, and neither kind of write disturbs the other. Full-width writes (double or long moves, single-extended results) work the same way in both modes. Integer multiplies also update negative and zero flags, which are taken from the whole 64-bit product.

The block has two combinational read ports. A read that targets the entry being written in the same cycle returns the value from before the write.

Top module: `split_lane_regfile`

## Requirements
- R1: `ctl_word` holds the last value written through `ctl_we`/`ctl_wdata`. The write takes effect on the next rising edge. Bit 5 of the word is `split_mode`: 1 means split mode is on, 0 means it is off. Reset clears the whole word.
- R2: Write kinds 3 (double or long move) and 4 (single-extended result) store all 96 bits of `wr_data`. This holds in both modes.
- R3: With split mode on, kinds 0 (single move) and 1 (single result) load bits 95:32 of `wr_data` into the upper and centre lanes. The bottom lane keeps its old value.
- R4: With split mode off, kinds 0 and 1 load bits 95:32 of `wr_data` into the upper and centre lanes and clear the bottom lane to zero.
- R5: With split mode on, kind 2 (integer multiply) writes `mul_prod[31:0]` into the bottom lane. The centre and upper lanes keep their old values.
- R6: With split mode off, kind 2 writes `mul_prod[31:0]` into the bottom lane and `mul_prod[63:32]` into the centre lane. The upper lane keeps its old value.
- R7: After a kind-2 write to a valid entry, `flag_n` equals `mul_prod[63]` and `flag_z` is 1 exactly when all 64 product bits are zero. Both flags change one edge after the write. No other operation changes them.
- R8: Both read ports are combinational. A read of the entry being written in the same cycle returns the value from before the write.
- R9: A write to an address of 10 or above changes no entry and no flag, and reading such an address returns zero. Write kinds 5 to 7 change nothing.
- R10: Reset clears all ten entries and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 32 | New control word; bit 5 turns split mode on |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Destination entry |
| wr_kind | input | 3 | Write kind, 0 to 4 (see requirements) |
| wr_data | input | 96 | Move or result data |
| mul_prod | input | 64 | Full integer product |
| rd_addr_a | input | 4 | Read address, port A |
| rd_data_a | output | 96 | Read data, port A |
| rd_addr_b | input | 4 | Read address, port B |
| rd_data_b | output | 96 | Read data, port B |
| ctl_word | output | 32 | Current control word |
| split_mode | output | 1 | Split mode is on |
| flag_n | output | 1 | Negative flag of the last multiply |
| flag_z | output | 1 | Zero flag of the last multiply |

## Verification
The main scenario loads one entry with a single-precision value and then interleaves single moves, single results and multiplies into it while split mode is on. A design that used the wrong lane masks would lose either the float or the integer, and the readback would show it. The same writes are repeated with split mode off, which catches a design that never clears the bottom lane or leaves the centre lane stale after a multiply.

The flag checks use a product whose low 32 bits are zero but whose upper half is not, and a product with only its sign bit set. A design that derived the flags from the stored 32 bits would raise zero on the first of these and miss negative on the second. Control words that change only bit 5, or every bit except bit 5, expose a wrong mode-bit position. A read of the entry under write in the same cycle, an out-of-range address and an unused kind show whether a design forwards write data or writes somewhere it should not.

// File: rtl/split_lane_regfile.sv
module split_lane_regfile #(
  parameter int NUM_REGS = 10,
  parameter int AW       = 4,
  parameter int LANE_W   = 32,
  parameter int CTL_W    = 32,
  parameter int MODE_BIT = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctl_we,
  input  logic [CTL_W-1:0]      ctl_wdata,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [2:0]            wr_kind,
  input  logic [3*LANE_W-1:0]   wr_data,
  input  logic [2*LANE_W-1:0]   mul_prod,
  input  logic [AW-1:0]         rd_addr_a,
  output logic [3*LANE_W-1:0]   rd_data_a,
  input  logic [AW-1:0]         rd_addr_b,
  output logic [3*LANE_W-1:0]   rd_data_b,
  output logic [CTL_W-1:0]      ctl_word,
  output logic                  split_mode,
  output logic                  flag_n,
  output logic                  flag_z
);
  localparam int ENT_W = 3 * LANE_W;
  localparam int PROD_W = 2 * LANE_W;
  localparam logic [2:0] K_SMOVE = 3'd0;
  localparam logic [2:0] K_SRES  = 3'd1;
  localparam logic [2:0] K_IMUL  = 3'd2;
  localparam logic [2:0] K_WMOVE = 3'd3;
  localparam logic [2:0] K_XRES  = 3'd4;

  logic [NUM_REGS-1:0][ENT_W-1:0] regs;
  logic up_we, mid_we, lo_we;
  logic [LANE_W-1:0] up_d, mid_d, lo_d;

  wire wr_hit = wr_en && (int'(wr_addr) < NUM_REGS);
  assign split_mode = ctl_word[MODE_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl_word <= '0;
    else if (ctl_we) ctl_word <= ctl_wdata;

  always_comb begin
    up_we  = 1'b0;
    mid_we = 1'b0;
    lo_we  = 1'b0;
    up_d   = wr_data[ENT_W-1:PROD_W];
    mid_d  = wr_data[PROD_W-1:LANE_W];
    lo_d   = wr_data[LANE_W-1:0];
    case (wr_kind)
      K_SMOVE, K_SRES: begin
        up_we  = 1'b1;
        mid_we = 1'b1;
        lo_we  = !split_mode;
        lo_d   = '0;
      end
      K_IMUL: begin
        lo_we  = 1'b1;
        mid_we = !split_mode;
        lo_d   = mul_prod[LANE_W-1:0];
        mid_d  = mul_prod[PROD_W-1:LANE_W];
      end
      K_WMOVE, K_XRES: begin
        up_we  = 1'b1;
        mid_we = 1'b1;
        lo_we  = 1'b1;
      end
      default: ;
    endcase
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    wire sel = wr_hit && (wr_addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) regs[i] <= '0;
      else if (sel) begin
        if (up_we)  regs[i][ENT_W-1:PROD_W]  <= up_d;
        if (mid_we) regs[i][PROD_W-1:LANE_W] <= mid_d;
        if (lo_we)  regs[i][LANE_W-1:0]      <= lo_d;
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else if (wr_hit && wr_kind == K_IMUL) begin
      flag_n <= mul_prod[PROD_W-1];
      flag_z <= ~|mul_prod;
    end

  assign rd_data_a = (int'(rd_addr_a) < NUM_REGS) ? regs[rd_addr_a] : '0;
  assign rd_data_b = (int'(rd_addr_b) < NUM_REGS) ? regs[rd_addr_b] : '0;
endmodule

// File: rtl/split_lane_regfile_chk.sv
module split_lane_regfile_chk #(
  parameter int NUM_REGS = 10,
  parameter int AW       = 4,
  parameter int LANE_W   = 32
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               ctl_we,
  input logic                               ctl_mode_in,
  input logic                               wr_en,
  input logic [AW-1:0]                      wr_addr,
  input logic [2:0]                         wr_kind,
  input logic [2*LANE_W-1:0]                mul_prod,
  input logic                               split_mode,
  input logic                               flag_n,
  input logic                               flag_z,
  input logic [NUM_REGS-1:0][3*LANE_W-1:0]  regs
);
  localparam int ENT_W = 3 * LANE_W;
  localparam int PROD_W = 2 * LANE_W;

  wire addr_ok = int'(wr_addr) < NUM_REGS;
  wire valid = wr_en && addr_ok;
  wire is_sp = wr_kind == 3'd0 || wr_kind == 3'd1;
  wire is_mul = wr_kind == 3'd2;
  logic [AW-1:0] q_addr;
  logic [ENT_W-1:0] q_old;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      q_addr <= '0;
      q_old  <= '0;
    end else begin
      q_addr <= wr_addr;
      q_old  <= addr_ok ? regs[wr_addr] : '0;
    end

  assert_ctl_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> split_mode == $past(ctl_mode_in));
  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(split_mode));
  assert_sp_keep_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid && is_sp && split_mode |=> regs[q_addr][LANE_W-1:0] == q_old[LANE_W-1:0]);
  assert_sp_clear_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid && is_sp && !split_mode |=> regs[q_addr][LANE_W-1:0] == '0);
  assert_mul_keep_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid && is_mul && split_mode |=> regs[q_addr][ENT_W-1:LANE_W] == q_old[ENT_W-1:LANE_W]);
  assert_mul_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid && is_mul |=> regs[q_addr][LANE_W-1:0] == $past(mul_prod[LANE_W-1:0]));
  assert_mul_keep_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid && is_mul |=> regs[q_addr][ENT_W-1:PROD_W] == q_old[ENT_W-1:PROD_W]);
  assert_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid && is_mul |=> flag_z == ($past(mul_prod) == '0) && flag_n == $past(mul_prod[PROD_W-1]));
  assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && is_mul) |=> $stable(flag_n) && $stable(flag_z));
  assert_bad_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !addr_ok |=> $stable(regs));
endmodule

bind split_lane_regfile split_lane_regfile_chk #(
  .NUM_REGS(NUM_REGS), .AW(AW), .LANE_W(LANE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_mode_in(ctl_wdata[MODE_BIT]),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_kind(wr_kind), .mul_prod(mul_prod),
  .split_mode(split_mode), .flag_n(flag_n), .flag_z(flag_z), .regs(regs)
);

// File: tb/tb_split_lane_regfile.sv
`timescale 1ns/1ps
module tb_split_lane_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [2:0] wr_kind = '0;
  logic [95:0] wr_data = '0;
  logic [63:0] mul_prod = '0;
  logic [3:0] rd_addr_a = '0, rd_addr_b = '0;
  logic [95:0] rd_data_a, rd_data_b;
  logic [31:0] ctl_word;
  logic split_mode, flag_n, flag_z;

  always #4 clk = ~clk;

  split_lane_regfile dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_kind(wr_kind), .wr_data(wr_data),
    .mul_prod(mul_prod), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .ctl_word(ctl_word),
    .split_mode(split_mode), .flag_n(flag_n), .flag_z(flag_z)
  );

  typedef struct packed {
    logic [95:0] val;
    logic        fn;
    logic        fz;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_chk = 0, n_fail = 0;
  logic [95:0] mdl [0:9];
  logic m_mode = 1'b0, m_fn = 1'b0, m_fz = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rd_data_a == e.val && rd_data_b == e.val, t, rd_data_a, e.val);
      check(flag_n == e.fn && flag_z == e.fz, {t, " flags"}, {94'd0, flag_n, flag_z}, {94'd0, e.fn, e.fz});
    end
  end

  task automatic expect_reg(input logic [3:0] a, input string tag);
    exp_t e;
    @(negedge clk); #2;
    rd_addr_a = a;
    rd_addr_b = a;
    e.val = (a < 10) ? mdl[a] : '0;
    e.fn = m_fn;
    e.fz = m_fz;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic op(input logic [2:0] k, input logic [3:0] a, input logic [95:0] d,
                    input logic [63:0] p, input string tag);
    @(negedge clk); #2;
    wr_en = 1'b1; wr_kind = k; wr_addr = a; wr_data = d; mul_prod = p;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (a < 10) begin
      case (k)
        3'd0, 3'd1: begin
          mdl[a][95:32] = d[95:32];
          if (!m_mode) mdl[a][31:0] = '0;
        end
        3'd2: begin
          mdl[a][31:0] = p[31:0];
          if (!m_mode) mdl[a][63:32] = p[63:32];
          m_fn = p[63];
          m_fz = (p == 64'd0);
        end
        3'd3, 3'd4: mdl[a] = d;
        default: ;
      endcase
    end
    expect_reg(a, tag);
  endtask

  task automatic ctl(input logic [31:0] w, input string tag);
    @(negedge clk); #2;
    ctl_we = 1'b1; ctl_wdata = w;
    @(posedge clk); #1;
    ctl_we = 1'b0;
    m_mode = w[5];
    @(negedge clk);
    check(ctl_word == w && split_mode == w[5], tag, {63'd0, split_mode, ctl_word}, {63'd0, w[5], w});
  endtask

  localparam logic [95:0] PA = {32'hA1A1_0001, 32'hB2B2_0002, 32'hC3C3_0003};
  localparam logic [95:0] PB = {32'h4040_0000, 32'h1234_5678, 32'hDEAD_BEEF};
  localparam logic [95:0] PC = {32'hBF80_0000, 32'h0F0F_F0F0, 32'h5555_AAAA};

  initial begin
    for (int i = 0; i < 10; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10 reset state, R1 control word cleared
    @(negedge clk);
    check(ctl_word == 32'd0 && !split_mode, "R1 reset ctl", {64'd0, ctl_word}, '0);
    for (int i = 0; i < 10; i++) expect_reg(4'(i), "R10 reset entry");

    // split mode off
    op(3'd3, 4'd0, PA, 64'd0, "R2 double move mode off");
    op(3'd4, 4'd1, PB, 64'd0, "R2 extended result mode off");
    op(3'd3, 4'd2, PA, 64'd0, "R2 preload");
    op(3'd0, 4'd2, PB, 64'd0, "R4 single move clears bottom");
    op(3'd3, 4'd3, PC, 64'd0, "R2 preload");
    op(3'd1, 4'd3, PA, 64'd0, "R4 single result clears bottom");
    op(3'd3, 4'd4, PA, 64'd0, "R2 preload");
    op(3'd2, 4'd4, PB, 64'h8000_0000_0000_0000, "R6 mult mode off sign only");
    op(3'd2, 4'd4, PB, 64'h0000_0001_0000_0000, "R6 R7 upper-only product not zero");

    // R1 bit position
    ctl(32'hFFFF_FFDF, "R1 all but bit5");
    op(3'd0, 4'd7, PC, 64'd0, "R4 mode still off");
    ctl(32'h0000_0020, "R1 only bit5");

    // R3 R5 interleave on entry 5
    op(3'd3, 4'd5, PC, 64'd0, "R2 full write mode on");
    op(3'd0, 4'd5, PB, 64'd0, "R3 single move keeps bottom");
    op(3'd2, 4'd5, PA, 64'h0000_0000_0000_0000, "R5 R7 zero product");
    op(3'd1, 4'd5, PA, 64'd0, "R3 single result keeps int");
    op(3'd2, 4'd5, PC, 64'hFFFF_FFFF_FFFF_FFF9, "R5 R7 negative product");
    op(3'd0, 4'd5, PC, 64'd0, "R3 float and int coexist");
    op(3'd2, 4'd5, PB, 64'h0000_0007_0000_0000, "R5 R7 low zero high set");
    op(3'd4, 4'd6, PB, 64'd0, "R2 extended result mode on");

    // R8 read during write
    @(negedge clk); #2;
    rd_addr_a = 4'd5; rd_addr_b = 4'd5;
    wr_en = 1'b1; wr_kind = 3'd3; wr_addr = 4'd5; wr_data = PA;
    #1 check(rd_data_a == mdl[5] && rd_data_b == mdl[5], "R8 old value during write", rd_data_a, mdl[5]);
    @(posedge clk); #1;
    wr_en = 1'b0;
    mdl[5] = PA;
    @(negedge clk);
    check(rd_data_a == PA, "R8 new value after edge", rd_data_a, PA);

    // R9 ignored writes
    op(3'd3, 4'd12, PC, 64'd0, "R9 out of range reads zero");
    op(3'd2, 4'd15, PC, 64'd0, "R9 bad addr mult leaves flags");
    op(3'd5, 4'd5, PC, 64'd0, "R9 kind 5 ignored");
    op(3'd7, 4'd0, PC, 64'd0, "R9 kind 7 ignored");
    for (int i = 0; i < 10; i++) expect_reg(4'(i), "R9 entries intact");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule